// File: doc/BRIEF.md
# Prioritised Interrupt Dispatch Controller

This block sits next to a small 8-bit processor core and decides when and where the core must jump to service an interrupt. It holds a five-bit request-flag register, an enable register and a master-enable bit. It also tracks whether the core is parked in its low-power halt state. Five peripherals raise request pulses. The core reads and writes the two registers through a byte-wide port. The core also signals instruction boundaries, halt entry, and master-enable changes with single-cycle strobes.

At each instruction boundary the block looks at the pending sources, which are those whose flag bit and enable bit are both set. If master enable is on, it presents the restart vector of the highest-priority pending source and holds that vector until the core acknowledges it. The acknowledgement clears that one flag bit and drops master enable. A pending source also wakes the core from halt whether or not master enable is on. A halt entered with master enable off while a source is already pending is reported on a separate anomaly output, and the block does not halt in that case.

Top module: `irq_dispatch`

## Requirements
- R1: After reset, the flag register reads 0xE0, the enable register reads 0x00, master enable is off, and `disp_valid`, `halted` and `halt_anom` are all 0.
- R2: A read at address 0xFF0F returns the flag bits in bits 4..0, with bits 7..5 always 1. Only bits 4..0 of that address are writable. Address 0xFFFF is a fully writable 8-bit enable register. Every other address reads 0x00.
- R3: A request pulse on `src_req[i]` sets flag bit i. This pulse takes precedence over a register write or an acknowledge clear to the same bit in the same cycle.
- R4: On a cycle with `step` high, master enable on, no dispatch outstanding, and at least one pending source, `disp_valid` rises in the next cycle. The vector is 0x40 + 8*i, where i is the lowest-indexed pending source. The sources are bit 0 vertical blank, bit 1 display status, bit 2 timer, bit 3 serial and bit 4 joypad. A source whose enable bit is 0 is never chosen.
- R5: While `disp_ack` is low, `disp_valid` stays high and `disp_vector` stays unchanged, even when higher-priority requests arrive.
- R6: An acknowledge clears only the flag bit of the dispatched source and turns master enable off, so a later step with sources pending produces no dispatch.
- R7: `ime_set` turns master enable on and `ime_clr` turns it off. When both arrive together, clear wins.
- R8: Halt entry with master enable on, or with no source pending, sets `halted`. `halted` stays set across steps while nothing is pending.
- R9: Halt entry with master enable off while a source is pending raises `halt_anom` for exactly one cycle and leaves `halted` at 0.
- R10: While halted, a step with a source pending clears `halted` in the next cycle. With master enable off, no dispatch is issued. With master enable on, the dispatch is issued in that same step.
- R11: Dispatch is evaluated only on `step`. A source pending without a step issues nothing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| src_req | input | 5 | Peripheral request pulses, bit 0 highest priority |
| bus_addr | input | 16 | Register port address |
| bus_wr | input | 1 | Register write strobe |
| bus_wdata | input | 8 | Register write data |
| bus_rdata | output | 8 | Register read data (combinational) |
| halt_enter | input | 1 | Core executes a halt |
| ime_set | input | 1 | Turn master enable on |
| ime_clr | input | 1 | Turn master enable off |
| step | input | 1 | Instruction boundary strobe |
| disp_ack | input | 1 | Core accepts the dispatch |
| disp_valid | output | 1 | Dispatch request outstanding |
| disp_vector | output | 8 | Restart vector of the dispatch |
| halted | output | 1 | Core is in low-power halt |
| halt_anom | output | 1 | One-cycle pulse: halt with pending source and master enable off |

## Verification
A wrong pending mask or priority order shows up on `disp_vector` one cycle after the step that takes the interrupt. Any flag bit cleared or kept in error appears in the flag read-back straight after the acknowledge. A master-enable bit stuck on or off cannot be read directly. It shows up as a dispatch that appears, or fails to appear, on the next step with a pending source. A wrong halt classification or wake rule shows on `halted` and `halt_anom` one cycle after the strobe that caused it.

// File: rtl/irq_dispatch.sv
module irq_dispatch #(
  parameter int          NSRC       = 5,
  parameter logic [15:0] FLAG_ADDR  = 16'hFF0F,
  parameter logic [15:0] EN_ADDR    = 16'hFFFF,
  parameter logic [7:0]  VEC_BASE   = 8'h40,
  parameter logic [7:0]  VEC_STRIDE = 8'h08
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [NSRC-1:0]  src_req,
  input  logic [15:0]      bus_addr,
  input  logic             bus_wr,
  input  logic [7:0]       bus_wdata,
  output logic [7:0]       bus_rdata,
  input  logic             halt_enter,
  input  logic             ime_set,
  input  logic             ime_clr,
  input  logic             step,
  input  logic             disp_ack,
  output logic             disp_valid,
  output logic [7:0]       disp_vector,
  output logic             halted,
  output logic             halt_anom
);
  localparam int PAD = 8 - NSRC;

  logic [NSRC-1:0] flag_q, flag_d, dsel_q, pend, pick_oh;
  logic [7:0]      en_q, dvec_q, pick_vec;
  logic            ime_q, halted_q, anom_q, dv_q;
  logic            wr_flag, wr_en, ack_fire, any_pend, take;

  assign wr_flag  = bus_wr && (bus_addr == FLAG_ADDR);
  assign wr_en    = bus_wr && (bus_addr == EN_ADDR);
  assign ack_fire = dv_q && disp_ack;
  assign pend     = flag_q & en_q[NSRC-1:0];
  assign any_pend = |pend;
  assign take     = step && ime_q && any_pend && !dv_q;

  always_comb begin
    pick_oh  = '0;
    pick_vec = '0;
    for (int i = NSRC - 1; i >= 0; i--) begin
      if (pend[i]) begin
        pick_oh    = '0;
        pick_oh[i] = 1'b1;
        pick_vec   = VEC_BASE + VEC_STRIDE * 8'(i);
      end
    end
  end

  always_comb begin
    flag_d = wr_flag ? bus_wdata[NSRC-1:0] : flag_q;
    if (ack_fire) flag_d = flag_d & ~dsel_q;
    flag_d = flag_d | src_req;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      flag_q   <= '0;
      en_q     <= '0;
      ime_q    <= 1'b0;
      halted_q <= 1'b0;
      anom_q   <= 1'b0;
      dv_q     <= 1'b0;
      dvec_q   <= '0;
      dsel_q   <= '0;
    end else begin
      flag_q <= flag_d;
      if (wr_en) en_q <= bus_wdata;

      if (ack_fire || ime_clr) ime_q <= 1'b0;
      else if (ime_set)        ime_q <= 1'b1;

      if (take) begin
        dv_q   <= 1'b1;
        dvec_q <= pick_vec;
        dsel_q <= pick_oh;
      end else if (ack_fire) begin
        dv_q <= 1'b0;
      end

      if (halt_enter && (ime_q || !any_pend))  halted_q <= 1'b1;
      else if (step && halted_q && any_pend)   halted_q <= 1'b0;

      anom_q <= halt_enter && !ime_q && any_pend;
    end
  end

  assign bus_rdata   = (bus_addr == FLAG_ADDR) ? {{PAD{1'b1}}, flag_q} :
                       (bus_addr == EN_ADDR)   ? en_q : 8'h00;
  assign disp_valid  = dv_q;
  assign disp_vector = dvec_q;
  assign halted      = halted_q;
  assign halt_anom   = anom_q;

  AST_HOLD_UNTIL_ACK: assert property (@(posedge clk) disable iff (!rst_n)
    dv_q && !disp_ack |=> dv_q && $stable(dvec_q)); // R5
  AST_DISP_NEEDS_IME: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(dv_q) |-> $past(ime_q) && $past(step)); // R4
  AST_ONE_SOURCE: assert property (@(posedge clk) disable iff (!rst_n)
    dv_q |-> $onehot0(dsel_q) && dsel_q != '0); // R4
  AST_ACK_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
    ack_fire && ((src_req & dsel_q) == '0) |=> ((flag_q & $past(dsel_q)) == '0) && !ime_q); // R6
  AST_ANOM_EXCL: assert property (@(posedge clk) disable iff (!rst_n)
    halt_anom |-> !$rose(halted_q)); // R9
  AST_ANOM_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
    anom_q && !halt_enter |=> !anom_q); // R9
endmodule

// File: tb/irq_dispatch_tb.sv
`timescale 1ns/100ps
module irq_dispatch_tb;
  logic clk = 1'b0, rst_n = 1'b0;
  logic [4:0] src_req = '0;
  logic [15:0] bus_addr = '0;
  logic bus_wr = 1'b0;
  logic [7:0] bus_wdata = '0, bus_rdata;
  logic halt_enter = 1'b0, ime_set = 1'b0, ime_clr = 1'b0, step = 1'b0, disp_ack = 1'b0;
  logic disp_valid, halted, halt_anom;
  logic [7:0] disp_vector;
  int ntest = 0, nfail = 0;

  always #2.5 clk = ~clk;

  irq_dispatch u_dut (
    .clk(clk), .rst_n(rst_n), .src_req(src_req), .bus_addr(bus_addr), .bus_wr(bus_wr),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .halt_enter(halt_enter), .ime_set(ime_set),
    .ime_clr(ime_clr), .step(step), .disp_ack(disp_ack), .disp_valid(disp_valid),
    .disp_vector(disp_vector), .halted(halted), .halt_anom(halt_anom));

  // {flags[4:0], enables[4:0], expected vector (0 = no dispatch)}
  localparam logic [17:0] TBL [7] = '{
    {5'h1F, 5'h1F, 8'h40}, {5'h1E, 5'h1F, 8'h48}, {5'h1C, 5'h1C, 8'h50},
    {5'h18, 5'h0F, 8'h58}, {5'h10, 5'h10, 8'h60}, {5'h0F, 5'h10, 8'h00},
    {5'h1F, 5'h00, 8'h00}};

  task automatic tick(); @(posedge clk); @(negedge clk); endtask
  task automatic chk(string req, logic [15:0] act, logic [15:0] exp);
    ntest++;
    if (act !== exp) begin
      nfail++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask
  task automatic wr(logic [15:0] a, logic [7:0] d);
    bus_addr = a; bus_wdata = d; bus_wr = 1'b1; tick(); bus_wr = 1'b0;
  endtask
  task automatic rd(logic [15:0] a, output logic [7:0] d);
    bus_addr = a; #1; d = bus_rdata;
  endtask
  task automatic do_step(); step = 1'b1; tick(); step = 1'b0; endtask
  task automatic do_ack(); disp_ack = 1'b1; tick(); disp_ack = 1'b0; endtask
  task automatic do_set(); ime_set = 1'b1; tick(); ime_set = 1'b0; endtask
  task automatic do_clr(); ime_clr = 1'b1; tick(); ime_clr = 1'b0; endtask
  task automatic do_halt(); halt_enter = 1'b1; tick(); halt_enter = 1'b0; endtask

  initial begin
    #(200000 * 5);
    nfail++; ntest++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("[TB] %0d tests run, %0d failed", ntest, nfail);
    $finish;
  end

  initial begin
    logic [7:0] d;
    @(negedge clk); @(negedge clk); rst_n = 1'b1; @(negedge clk);
    // R1
    rd(16'hFF0F, d); chk("R1 flag reset", d, 8'hE0);
    rd(16'hFFFF, d); chk("R1 enable reset", d, 8'h00);
    chk("R1 outputs", {disp_valid, halted, halt_anom}, 3'b000);
    do_step(); chk("R1 ime off", disp_valid, 1'b0);

    // R4 R6 table
    foreach (TBL[k]) begin
      logic [4:0] fl = TBL[k][17:13];
      logic [4:0] en = TBL[k][12:8];
      logic [7:0] ev = TBL[k][7:0];
      wr(16'hFF0F, {3'b0, fl}); wr(16'hFFFF, {3'b0, en});
      do_set(); do_step();
      chk("R4 valid", disp_valid, ev != 0);
      if (ev != 0) begin
        int idx = (ev - 8'h40) / 8;
        chk("R4 vector", disp_vector, ev);
        do_ack();
        chk("R6 valid drop", disp_valid, 1'b0);
        rd(16'hFF0F, d); chk("R6 flag clear", d, {3'b111, fl & ~(5'd1 << idx)});
      end
      wr(16'hFF0F, 8'h00); do_clr();
    end

    // R2
    wr(16'hFF0F, 8'hFF); rd(16'hFF0F, d); chk("R2 flag all", d, 8'hFF);
    wr(16'hFF0F, 8'h00); rd(16'hFF0F, d); chk("R2 flag zero", d, 8'hE0);
    wr(16'hFFFF, 8'hA5); rd(16'hFFFF, d); chk("R2 enable", d, 8'hA5);
    rd(16'h1234, d); chk("R2 other addr", d, 8'h00);

    // R3
    src_req = 5'b00100; wr(16'hFF0F, 8'h00); src_req = '0;
    rd(16'hFF0F, d); chk("R3 req beats write", d, 8'hE4);
    wr(16'hFF0F, 8'h00);

    // R11 and R5
    wr(16'hFFFF, 8'h1F); wr(16'hFF0F, 8'h08); do_set();
    tick(); tick(); chk("R11 no step", disp_valid, 1'b0);
    do_step(); chk("R5 vec", disp_vector, 8'h58);
    src_req = 5'b00001; tick(); src_req = '0; tick(); tick();
    chk("R5 held valid", disp_valid, 1'b1);
    chk("R5 held vector", disp_vector, 8'h58);
    // R3: request on dispatched bit during ack wins
    src_req = 5'b01000; do_ack(); src_req = '0;
    rd(16'hFF0F, d); chk("R3 req beats ack", d, 8'hE9);
    // R6: ime dropped by ack
    do_step(); chk("R6 no dispatch after ack", disp_valid, 1'b0);

    // R7
    ime_set = 1'b1; ime_clr = 1'b1; tick(); ime_set = 1'b0; ime_clr = 1'b0;
    do_step(); chk("R7 clr wins", disp_valid, 1'b0);
    do_set(); do_step(); chk("R7 set", disp_vector, 8'h40);
    do_ack(); wr(16'hFF0F, 8'h00);

    // R8 none pending, R10 wake without dispatch
    do_halt(); chk("R8 halted none", halted, 1'b1);
    do_step(); chk("R8 stays halted", halted, 1'b1);
    src_req = 5'b10000; tick(); src_req = '0;
    chk("R10 still halted before step", halted, 1'b1);
    do_step(); chk("R10 woke", halted, 1'b0);
    chk("R10 no dispatch", disp_valid, 1'b0);

    // R9 pending with ime off
    do_halt(); chk("R9 anom", {halt_anom, halted}, 2'b10);
    tick(); chk("R9 pulse ends", halt_anom, 1'b0);
    wr(16'hFF0F, 8'h00);

    // R8 enabled kind, R10 wake with dispatch
    do_set(); do_halt(); chk("R8 halted enabled", {halted, halt_anom}, 2'b10);
    src_req = 5'b00010; tick(); src_req = '0;
    do_step(); chk("R10 woke ime", halted, 1'b0);
    chk("R10 dispatch", {7'b0, disp_valid, disp_vector}, 16'h0148);
    do_ack();

    $display("[TB] %0d tests run, %0d failed", ntest, nfail);
    $finish;
  end
endmodule